// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with Destination Filter

This block is the receive end of a small Ethernet MAC. Frames come in as a byte stream, one byte per cycle while `rxValid` is high. `rxSof` marks the first byte and `rxLast` marks the final one, and `rxGood` qualifies the final byte as free of errors. The block checks the six-byte destination address as it arrives. A frame that passes is written into one of two receive buffers, and that buffer's status bit is set. Software reads the stored bytes and then clears the status bit to return the buffer.

When `pingPongEn` is high, the block switches to the other buffer after each accepted frame, so one frame can arrive while software drains the previous one. When `pingPongEn` is low, every frame lands in buffer 0. Frames are dropped in three cases: the selected buffer is still full, the address check fails, or the frame has a bad length or error flag. A frame dropped because the buffer was full is reported on a one-cycle loss pulse. An accepted frame can raise a one-cycle interrupt pulse.

Top module: `rx_pingpong_filter`

## Requirements
- R1: After reset the block selects buffer 0. Both control registers read zero, `rxReady` is 1, and `irqPulse` and `lostPulse` are 0.
- R2: Byte k of an accepted frame (k counted from 0 at `rxSof`) reads back at index k of the buffer that was selected when the frame started. Bit 0 of that buffer's control register (the full flag) is 1 in the cycle after the final byte.
- R3: With bit 7 of the first byte clear, a frame is accepted only when its first six bytes equal `stationMac`, taken most significant byte first (`stationMac[47:40]` is byte 0). A frame that differs in any bit of those six bytes leaves both full flags, the selector and the stored contents of full buffers unchanged.
- R4: A frame whose first byte has bit 7 set is accepted whatever its remaining destination bytes are.
- R5: A frame is not accepted if `rxGood` is 0 on its final byte or if it has fewer than 6 bytes.
- R6: A frame longer than `BUF_BYTES` bytes is not accepted. A frame of exactly `BUF_BYTES` bytes is accepted.
- R7: If a frame starts while the selected buffer's full flag is 1, the frame is dropped, `lostPulse` is high for one cycle, and the buffer's contents and flag are unchanged.
- R8: `rxReady` equals the inverse of the full flag of the buffer named by `curBuf`.
- R9: After each accepted frame, `curBuf` toggles when `pingPongEn` is 1 and becomes 0 when `pingPongEn` is 0. `curBuf` does not change on any other event.
- R10: `irqPulse` is high for exactly one cycle after an accepted frame, and only when `irqGlobalEn` is 1 and bit 3 of buffer 0's control register is 1. This applies to frames stored in either buffer.
- R11: A software write stores all `CTRL_W` bits into the addressed control register, so writing bit 0 as 0 releases the buffer. If a frame is accepted into the same buffer in the same cycle, bit 0 still ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A receive byte is present this cycle |
| rxSof | input | 1 | First byte of a frame |
| rxLast | input | 1 | Final byte of a frame |
| rxGood | input | 1 | Frame is free of errors; sampled with the final byte |
| rxData | input | 8 | Receive byte |
| stationMac | input | 48 | Station address, byte 0 in bits 47:40 |
| pingPongEn | input | 1 | Alternate between the two buffers |
| irqGlobalEn | input | 1 | Global interrupt enable |
| swWrEn | input | 1 | Software control-register write strobe |
| swWrBuf | input | 1 | Buffer addressed by the write |
| swWrData | input | CTRL_W | Control value to store |
| rdBuf | input | 1 | Buffer to read |
| rdIdx | input | $clog2(BUF_BYTES) | Byte index to read |
| rdByte | output | 8 | Stored byte (combinational read) |
| ctrlRd0 | output | CTRL_W | Buffer 0 control register |
| ctrlRd1 | output | CTRL_W | Buffer 1 control register |
| rxReady | output | 1 | Selected buffer can take a frame |
| curBuf | output | 1 | Currently selected buffer |
| irqPulse | output | 1 | One-cycle interrupt on an accepted frame |
| lostPulse | output | 1 | One-cycle pulse for a frame dropped because the buffer was full |

## Verification
Suppose the match or group flag carried from byte to byte is wrong. Then a frame is either accepted or discarded in error, and the full flags on `ctrlRd0`/`ctrlRd1` and `curBuf` show the mistake in the cycle after the final byte. Suppose instead the selector or a full flag goes stale. Then `rxReady` disagrees with the visible control register at once, and the next frame is either lost when it should not be or written over a full buffer. An error in the write index or byte order appears only when the stored bytes are read back, so every full buffer is compared in full after each frame.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrByte;
    logic commit;
    logic bufSel;
  } rxStrobe_t;

  localparam int MAC_BYTES = 6;

  function automatic logic [7:0] macByteAt(input logic [47:0] mac, input int idx);
    if (idx < 0 || idx >= MAC_BYTES) return 8'h00;
    return mac[47 - 8*idx -: 8];
  endfunction

endpackage

// File: rtl/rxpf_ctrl.sv
module rxpf_ctrl
  import rxpf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int AW        = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic          rxSof,
  input  logic          rxLast,
  input  logic          rxGood,
  input  logic [7:0]    rxData,
  input  logic [47:0]   stationMac,
  input  logic          pingPongEn,
  input  logic          irqGlobalEn,
  input  logic [1:0]    statusBits,
  input  logic          irqArm,
  output rxStrobe_t     strb,
  output logic [AW-1:0] wrIdx,
  output logic          curBuf,
  output logic          rxReady,
  output logic          irqPulse,
  output logic          lostPulse
);
  localparam int IW = $clog2(BUF_BYTES + 1);
  localparam logic [IW-1:0] HDR_LAST = IW'(MAC_BYTES - 1);
  localparam logic [IW-1:0] HDR_LEN  = IW'(MAC_BYTES);
  localparam logic [IW-1:0] BUF_IDX  = IW'(BUF_BYTES);

  rxState_t      stQ;
  logic [IW-1:0] idxQ, effIdx, idxNext;
  logic          grpQ, eqQ;
  logic          isFull, startB, takeB, effGrp, effEq, addrOk, hdrByte, fits, longEnough;

  always_comb begin
    isFull     = statusBits[curBuf];
    startB     = rxValid && rxSof;
    effIdx     = startB ? '0 : idxQ;
    takeB      = startB ? !isFull : (stQ == ST_RECV && rxValid);
    hdrByte    = effIdx < HDR_LEN;
    effGrp     = (effIdx == '0) ? rxData[7] : grpQ;
    effEq      = ((effIdx == '0) ? 1'b1 : eqQ) &&
                 (!hdrByte || rxData == macByteAt(stationMac, int'(effIdx)));
    addrOk     = effGrp || effEq;
    fits       = effIdx < BUF_IDX;
    longEnough = effIdx >= HDR_LAST;
    idxNext    = (effIdx == BUF_IDX) ? effIdx : effIdx + IW'(1);
    strb.wrByte = takeB && fits;
    strb.commit = takeB && rxLast && rxGood && longEnough && fits && addrOk;
    strb.bufSel = curBuf;
    wrIdx       = effIdx[AW-1:0];
    rxReady     = !isFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ       <= ST_IDLE;
      idxQ      <= '0;
      grpQ      <= 1'b0;
      eqQ       <= 1'b0;
      curBuf    <= 1'b0;
      irqPulse  <= 1'b0;
      lostPulse <= 1'b0;
    end else begin
      irqPulse  <= strb.commit && irqArm && irqGlobalEn;
      lostPulse <= startB && isFull;
      if (strb.commit) curBuf <= pingPongEn ? !curBuf : 1'b0;
      if (takeB) begin
        idxQ <= idxNext;
        grpQ <= effGrp;
        eqQ  <= effEq;
        if (rxLast)                          stQ <= ST_IDLE;
        else if (effIdx == HDR_LAST && !addrOk) stQ <= ST_DROP;
        else                                 stQ <= ST_RECV;
      end else if (startB) begin
        stQ <= rxLast ? ST_IDLE : ST_DROP;
      end else if (rxValid && rxLast) begin
        stQ <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/rxpf_datapath.sv
module rxpf_datapath
  import rxpf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int CTRL_W    = 4,
  parameter int AW        = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [AW-1:0]     wrIdx,
  input  logic [7:0]        wrData,
  input  logic              swWrEn,
  input  logic              swWrBuf,
  input  logic [CTRL_W-1:0] swWrData,
  input  logic              rdBuf,
  input  logic [AW-1:0]     rdIdx,
  output logic [7:0]        rdByte,
  output logic [1:0]        statusBits,
  output logic              irqArm,
  output logic [CTRL_W-1:0] ctrlRd0,
  output logic [CTRL_W-1:0] ctrlRd1
);
  localparam int NBUF    = 2;
  localparam int IRQ_BIT = 3;

  logic [7:0]        mem [NBUF][BUF_BYTES];
  logic [CTRL_W-1:0] ctrlQ [NBUF];

  always_ff @(posedge clk) begin
    if (strb.wrByte) mem[strb.bufSel][wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NBUF; b++) ctrlQ[b] <= '0;
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        if (swWrEn && swWrBuf == 1'(b)) ctrlQ[b] <= swWrData;
        if (strb.commit && strb.bufSel == 1'(b)) ctrlQ[b][0] <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_status
      assign statusBits[g] = ctrlQ[g][0];
    end
  endgenerate

  assign irqArm  = ctrlQ[0][IRQ_BIT];
  assign ctrlRd0 = ctrlQ[0];
  assign ctrlRd1 = ctrlQ[1];
  assign rdByte  = mem[rdBuf][rdIdx];

endmodule

// File: rtl/rx_pingpong_filter.sv
module rx_pingpong_filter
  import rxpf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int CTRL_W    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxValid,
  input  logic                         rxSof,
  input  logic                         rxLast,
  input  logic                         rxGood,
  input  logic [7:0]                   rxData,
  input  logic [47:0]                  stationMac,
  input  logic                         pingPongEn,
  input  logic                         irqGlobalEn,
  input  logic                         swWrEn,
  input  logic                         swWrBuf,
  input  logic [CTRL_W-1:0]            swWrData,
  input  logic                         rdBuf,
  input  logic [$clog2(BUF_BYTES)-1:0] rdIdx,
  output logic [7:0]                   rdByte,
  output logic [CTRL_W-1:0]            ctrlRd0,
  output logic [CTRL_W-1:0]            ctrlRd1,
  output logic                         rxReady,
  output logic                         curBuf,
  output logic                         irqPulse,
  output logic                         lostPulse
);
  localparam int AW = $clog2(BUF_BYTES);

  rxStrobe_t     strb;
  logic [AW-1:0] wrIdx;
  logic [1:0]    statusBits;
  logic          irqArm;

  rxpf_ctrl #(.BUF_BYTES(BUF_BYTES), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxLast(rxLast),
    .rxGood(rxGood), .rxData(rxData), .stationMac(stationMac),
    .pingPongEn(pingPongEn), .irqGlobalEn(irqGlobalEn),
    .statusBits(statusBits), .irqArm(irqArm), .strb(strb), .wrIdx(wrIdx),
    .curBuf(curBuf), .rxReady(rxReady), .irqPulse(irqPulse), .lostPulse(lostPulse)
  );

  rxpf_datapath #(.BUF_BYTES(BUF_BYTES), .CTRL_W(CTRL_W), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(rxData),
    .swWrEn(swWrEn), .swWrBuf(swWrBuf), .swWrData(swWrData),
    .rdBuf(rdBuf), .rdIdx(rdIdx), .rdByte(rdByte),
    .statusBits(statusBits), .irqArm(irqArm), .ctrlRd0(ctrlRd0), .ctrlRd1(ctrlRd1)
  );

endmodule

// File: rtl/rxpf_checker.sv
module rxpf_checker #(
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              rxSof,
  input logic              rxReady,
  input logic              curBuf,
  input logic              pingPongEn,
  input logic              irqPulse,
  input logic              irqGlobalEn,
  input logic              lostPulse,
  input logic              swWrEn,
  input logic              swWrBuf,
  input logic [CTRL_W-1:0] swWrData,
  input logic [CTRL_W-1:0] ctrlRd0,
  input logic [CTRL_W-1:0] ctrlRd1
);
  localparam logic [CTRL_W-1:0] LSB = CTRL_W'(1);

  // R8
  ready_tracks_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReady == !(curBuf ? ctrlRd1[0] : ctrlRd0[0]));

  // R7
  lost_only_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    lostPulse |-> $past(rxValid && rxSof && !rxReady));

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(irqGlobalEn) && $past(ctrlRd0[3])));

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R9
  sel_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(curBuf) |-> $past(pingPongEn));

  // R11
  ctrl0_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(swWrEn && !swWrBuf) |-> ((ctrlRd0 | LSB) == ($past(swWrData) | LSB)));

  // R11
  ctrl1_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(swWrEn && swWrBuf) |-> ((ctrlRd1 | LSB) == ($past(swWrData) | LSB)));

endmodule

bind rx_pingpong_filter rxpf_checker #(.CTRL_W(CTRL_W)) chk_i (.*);

// File: tb/rx_pingpong_filter_tb_top.sv
module rx_pingpong_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 16;
  localparam int CW  = 4;
  localparam int AW  = $clog2(BUF);
  localparam logic [47:0] MAC = 48'h021A2B3C4D5E;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxSof = 0, rxLast = 0, rxGood = 0;
  logic [7:0] rxData = '0;
  logic pingPongEn = 0, irqGlobalEn = 0;
  logic swWrEn = 0, swWrBuf = 0;
  logic [CW-1:0] swWrData = '0;
  logic rdBuf = 0;
  logic [AW-1:0] rdIdx = '0;
  logic [7:0] rdByte;
  logic [CW-1:0] ctrlRd0, ctrlRd1;
  logic rxReady, curBuf, irqPulse, lostPulse;

  rx_pingpong_filter #(.BUF_BYTES(BUF), .CTRL_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxLast(rxLast),
    .rxGood(rxGood), .rxData(rxData), .stationMac(MAC), .pingPongEn(pingPongEn),
    .irqGlobalEn(irqGlobalEn), .swWrEn(swWrEn), .swWrBuf(swWrBuf), .swWrData(swWrData),
    .rdBuf(rdBuf), .rdIdx(rdIdx), .rdByte(rdByte), .ctrlRd0(ctrlRd0), .ctrlRd1(ctrlRd1),
    .rxReady(rxReady), .curBuf(curBuf), .irqPulse(irqPulse), .lostPulse(lostPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0]    frm [32];
  logic [7:0]    mMem [2][BUF];
  int            mLen [2];
  logic [CW-1:0] mCtrl [2];
  logic          mSel;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic swWrite(input logic b, input logic [CW-1:0] v);
    @(negedge clk);
    swWrEn = 1; swWrBuf = b; swWrData = v;
    @(negedge clk);
    swWrEn = 0;
    mCtrl[b] = v;
  endtask

  task automatic buildFrame(input int len, input int seed);
    for (int i = 0; i < len; i++)
      frm[i] = (i < 6) ? MAC[47-8*i -: 8] : 8'((i*13 + seed*7 + 1) & 255);
  endtask

  task automatic runFrame(input int len, input logic good, input string tag);
    logic addrOk, isFull, acc, irqExp, irqSeen, lostSeen, tgt;
    addrOk = frm[0][7];
    if (!addrOk) begin
      addrOk = 1'b1;
      for (int j = 0; j < 6; j++) if (frm[j] != MAC[47-8*j -: 8]) addrOk = 1'b0;
    end
    isFull = mCtrl[mSel][0];
    acc = !isFull && good && len >= 6 && len <= BUF && addrOk;
    irqSeen = 0; lostSeen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      irqSeen |= irqPulse; lostSeen |= lostPulse;
      rxValid = 1; rxSof = (i == 0); rxLast = (i == len-1);
      rxGood = (i == len-1) ? good : 1'b1; rxData = frm[i];
    end
    @(negedge clk);
    irqSeen |= irqPulse; lostSeen |= lostPulse;
    rxValid = 0; rxSof = 0; rxLast = 0; rxGood = 0;
    @(negedge clk);
    irqSeen |= irqPulse; lostSeen |= lostPulse;
    irqExp = 1'b0;
    tgt = mSel;
    if (acc) begin
      mCtrl[tgt][0] = 1'b1;
      for (int i = 0; i < len; i++) mMem[tgt][i] = frm[i];
      mLen[tgt] = len;
      irqExp = mCtrl[0][3] && irqGlobalEn;
      mSel = pingPongEn ? !mSel : 1'b0;
    end
    chk(32'(lostSeen), 32'(isFull), {tag, " R7 lost"});
    chk(32'(irqSeen), 32'(irqExp), {tag, " R10 irq"});
    chk(32'(curBuf), 32'(mSel), {tag, " R9 sel"});
    chk(32'(ctrlRd0), 32'(mCtrl[0]), {tag, " R2 ctrl0"});
    chk(32'(ctrlRd1), 32'(mCtrl[1]), {tag, " R2 ctrl1"});
    chk(32'(rxReady), 32'(!mCtrl[mSel][0]), {tag, " R8 ready"});
    for (int b = 0; b < 2; b++) begin
      if (mCtrl[b][0]) begin
        for (int i = 0; i < mLen[b]; i++) begin
          rdBuf = 1'(b); rdIdx = AW'(i);
          #1;
          chk(32'(rdByte), 32'(mMem[b][i]), {tag, " R2 data"});
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mCtrl[0] = '0; mCtrl[1] = '0; mSel = 0; mLen[0] = 0; mLen[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(32'(curBuf), 0, "R1 curBuf");
    chk(32'(rxReady), 1, "R1 rxReady");
    chk(32'(ctrlRd0), 0, "R1 ctrl0");
    chk(32'(ctrlRd1), 0, "R1 ctrl1");
    chk(32'({irqPulse, lostPulse}), 0, "R1 pulses");

    // R5 R6 length sweep, single buffer
    for (int len = 1; len <= 20; len++) begin
      buildFrame(len, len);
      runFrame(len, 1'b1, "R5 R6 len");
      if (mCtrl[0][0]) swWrite(1'b0, '0);
    end

    // R3 single-bit destination mismatch at every header bit
    for (int pos = 0; pos < 6; pos++) begin
      for (int bt = 0; bt < 8; bt++) begin
        if (!(pos == 0 && bt == 7)) begin
          buildFrame(10, pos + bt);
          frm[pos] = frm[pos] ^ (8'h01 << bt);
          runFrame(10, 1'b1, "R3 mismatch");
        end
      end
    end

    // R4 group destination
    for (int k = 0; k < 4; k++) begin
      buildFrame(12, k);
      for (int j = 0; j < 6; j++) frm[j] = 8'(8'hA5 + j*k);
      frm[0] = 8'h80 | 8'(k);
      runFrame(12, 1'b1, "R4 group");
      swWrite(1'b0, '0);
    end

    // R5 error flag
    buildFrame(10, 9);
    runFrame(10, 1'b0, "R5 bad");

    // R7 full buffer drop with content kept
    buildFrame(8, 3);
    runFrame(8, 1'b1, "R2 accept");
    buildFrame(9, 4);
    runFrame(9, 1'b1, "R7 full");
    swWrite(1'b0, '0);

    // R9 ping-pong alternation
    pingPongEn = 1;
    for (int k = 0; k < 3; k++) begin
      buildFrame(7 + k, 5 + k);
      runFrame(7 + k, 1'b1, "R9 pingpong");
    end
    swWrite(1'b1, '0);
    // R10 interrupt armed from buffer 0 control for both buffers
    swWrite(1'b0, 4'b1000);
    irqGlobalEn = 1;
    buildFrame(11, 20); runFrame(11, 1'b1, "R10 irq b0");
    buildFrame(13, 21); runFrame(13, 1'b1, "R10 irq b1");
    swWrite(1'b0, 4'b1000);
    swWrite(1'b1, '0);
    irqGlobalEn = 0;
    buildFrame(9, 22); runFrame(9, 1'b1, "R10 gie off");
    irqGlobalEn = 1;
    swWrite(1'b0, '0);
    buildFrame(9, 23); runFrame(9, 1'b1, "R10 arm off");
    swWrite(1'b1, '0);

    // R9 ping-pong disabled returns to buffer 0
    buildFrame(8, 24); runFrame(8, 1'b1, "R9 to b1");
    pingPongEn = 0;
    buildFrame(8, 25); runFrame(8, 1'b1, "R9 pp off");
    chk(32'(curBuf), 0, "R9 back to 0");

    // R11 stored control bits
    swWrite(1'b1, 4'b0110);
    chk(32'(ctrlRd1), 32'(4'b0110), "R11 store");
    chk(32'(rxReady), 32'(!mCtrl[0][0]), "R11 R8 ready");
    swWrite(1'b0, 4'b1010);
    chk(32'(ctrlRd0), 32'(4'b1010), "R11 store0");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule